// File: doc/BRIEF.md
# SPI Serial Port Controller

This block is a synchronous serial port that can act as either the clocking side (master) or the clocked side (slave) of an SPI link. An 8-bit control register selects the role, the SCK source and the SCK idle level. It also holds two sticky error flags. Software reaches the port over a small register bus. One buffer register carries both directions: a write supplies the next byte to send, and a read returns the last byte received. A separate register holds the reload value for the programmable divider, and a status register reports whether the buffer holds unread data.

As master, a buffer write starts one 8-bit transfer. SCK comes from a fixed divider of the system clock, from a programmable divider, or from an external timer tick. As slave, the port follows an external SCK, which it synchronises internally. It can optionally be gated by an active-low select line. When the port is disabled, or a reserved mode is selected, both output enables are low so the pins can serve other uses.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and both `sck_oe` and `sdo_oe` are low.
- R2: `bus_sel` chooses the register: 0 control, 1 data buffer, 2 reload, 3 status. `bus_rdata` carries the selected value in the cycle after `bus_rd`. Control bits are: 7 write-collision, 6 receive-overflow, 5 enable, 4 clock polarity, 3:0 mode. Status bit 0 is buffer-full.
- R3: In master modes 0000, 0001 and 0010, each SCK half-period lasts 2, 8 and 32 system clocks respectively (SCK = clk/4, /16, /64).
- R4: In master mode 0011, SCK toggles once per `timer_tick` pulse, so SCK runs at half the tick rate.
- R5: In master mode 1010, each SCK half-period lasts 2*(reload+1) system clocks.
- R6: As master, a buffer write made while no transfer is running produces exactly eight SCK cycles. Data is sent MSB first on `sdo`. `sdi` is captured on each leading edge (the edge away from the idle level). When the transfer ends, the received byte goes to the buffer and buffer-full is set.
- R7: SCK rests at the level of the polarity bit: high when it is 1, low when it is 0.
- R8: A buffer write while a byte is still shifting sets the write-collision flag and is otherwise ignored. The flag stays set until a control write with bit 7 = 0.
- R9: In slave modes, the byte loaded through the buffer is shifted out MSB first on external SCK. The byte shifted in lands in the buffer and sets buffer-full.
- R10: In slave mode, a byte that completes while buffer-full is set sets the receive-overflow flag (sticky until a control write with bit 6 = 0). The new byte is discarded and the buffer keeps the older byte.
- R11: In master modes, the receive-overflow flag never becomes set. Each completed transfer overwrites the buffer.
- R12: In slave mode 0100, a high `ss_n` lowers `sdo_oe`, makes SCK edges have no effect and restarts the bit count. In mode 0101, `ss_n` is ignored.
- R13: With enable at 0, or with any mode other than 0000, 0001, 0010, 0011, 0100, 0101 or 1010, both output enables are low and buffer writes start nothing.
- R14: A buffer read clears buffer-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| timer_tick | input | 1 | External tick for timer-clocked master mode |
| sck_in | input | 1 | SCK from an external master |
| sck_out | output | 1 | SCK driven as master |
| sck_oe | output | 1 | SCK output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
A bit counter that drifts shows up on the pins within one transfer. The master emits more or fewer than sixteen SCK toggles, or the slave deposits a byte one bit off, and the next buffer read exposes it. A divider limit held wrong shows in the very first SCK half-period measured after the start write. A stuck busy or flag state appears at the next control or status read: either a collision flag that should not be there, or an overflow that swallowed a byte. A broken deselect reset shows as a corrupted byte on the first full transfer after an aborted one.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  typedef enum logic [2:0] {
    SRC_DIV4   = 3'd0,
    SRC_DIV16  = 3'd1,
    SRC_DIV64  = 3'd2,
    SRC_TIMER  = 3'd3,
    SRC_RELOAD = 3'd4
  } clk_src_e;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_BUF    = 2'd1;
  localparam logic [1:0] SEL_RELOAD = 2'd2;
  localparam logic [1:0] SEL_STAT   = 2'd3;

  typedef struct packed {
    role_e    role;
    clk_src_e src;
    logic     ss_ctl;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic en, input logic [3:0] m);
    mode_cfg_t c;
    c.role   = ROLE_OFF;
    c.src    = SRC_DIV4;
    c.ss_ctl = 1'b0;
    if (en) begin
      case (m)
        4'h0: begin c.role = ROLE_MASTER; c.src = SRC_DIV4;   end
        4'h1: begin c.role = ROLE_MASTER; c.src = SRC_DIV16;  end
        4'h2: begin c.role = ROLE_MASTER; c.src = SRC_DIV64;  end
        4'h3: begin c.role = ROLE_MASTER; c.src = SRC_TIMER;  end
        4'hA: begin c.role = ROLE_MASTER; c.src = SRC_RELOAD; end
        4'h4: begin c.role = ROLE_SLAVE;  c.ss_ctl = 1'b1;    end
        4'h5: begin c.role = ROLE_SLAVE;  c.ss_ctl = 1'b0;    end
        default: c.role = ROLE_OFF;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen import spi_port_pkg::*; #(
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  clk_src_e            src,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                timer_tick,
  output logic                half_pulse
);

  localparam int CW = RELOAD_W + 2;

  logic [CW-1:0] limit;
  logic [CW-1:0] cnt;

  // half-period length in system clocks for each divided source
  always_comb begin
    case (src)
      SRC_DIV16:  limit = CW'(8);
      SRC_DIV64:  limit = CW'(32);
      SRC_RELOAD: limit = {1'b0, reload, 1'b0} + CW'(2);
      default:    limit = CW'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt        <= '0;
      half_pulse <= 1'b0;
    end else if (src == SRC_TIMER) begin
      cnt        <= '0;
      half_pulse <= timer_tick;
    end else if (cnt == limit - CW'(1)) begin
      cnt        <= '0;
      half_pulse <= 1'b1;
    end else begin
      cnt        <= cnt + CW'(1);
      half_pulse <= 1'b0;
    end
  end

  // R3: a divided source never yields back-to-back half-period pulses
  p_pulse_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (half_pulse && src != SRC_TIMER) |=> !half_pulse);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter import spi_port_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  role_e        role,
  input  logic         ss_ctl,
  input  logic         cpol,
  input  logic         half_pulse,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sdi_raw,
  input  logic         sdi_s,
  input  logic         sck_s,
  input  logic         ss_n_s,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_data,
  output logic         sck_lvl,
  output logic         sdo_bit
);

  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             samp;
  logic             lead;
  logic             mbusy;
  logic             sck_d;
  logic             lead_edge;
  logic             trail_edge;

  assign lead_edge  = (sck_s != sck_d) && (sck_s != cpol);
  assign trail_edge = (sck_s != sck_d) && (sck_s == cpol);

  always_comb begin
    case (role)
      ROLE_MASTER: busy = mbusy;
      ROLE_SLAVE:  busy = lead || (bitcnt != '0);
      default:     busy = 1'b0;
    endcase
  end

  assign rx_data = shreg;
  assign sdo_bit = shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bitcnt  <= '0;
      samp    <= 1'b0;
      lead    <= 1'b0;
      mbusy   <= 1'b0;
      done    <= 1'b0;
      sck_lvl <= 1'b0;
      sck_d   <= 1'b0;
    end else begin
      sck_d <= sck_s;
      done  <= 1'b0;
      case (role)
        ROLE_MASTER: begin
          if (load && !mbusy) begin
            shreg   <= load_data;
            mbusy   <= 1'b1;
            bitcnt  <= '0;
            lead    <= 1'b0;
            sck_lvl <= cpol;
          end else if (mbusy && half_pulse) begin
            sck_lvl <= ~sck_lvl;
            if (!lead) begin
              samp <= sdi_raw;
              lead <= 1'b1;
            end else begin
              lead  <= 1'b0;
              shreg <= {shreg[W-2:0], samp};
              if (bitcnt == LAST) begin
                bitcnt <= '0;
                mbusy  <= 1'b0;
                done   <= 1'b1;
              end else begin
                bitcnt <= bitcnt + CNT_W'(1);
              end
            end
          end else if (!mbusy) begin
            sck_lvl <= cpol;
          end
        end
        ROLE_SLAVE: begin
          mbusy   <= 1'b0;
          sck_lvl <= cpol;
          if (ss_ctl && ss_n_s) begin
            bitcnt <= '0;
            lead   <= 1'b0;
          end else if (lead_edge && !lead) begin
            samp <= sdi_s;
            lead <= 1'b1;
          end else if (trail_edge && lead) begin
            lead  <= 1'b0;
            shreg <= {shreg[W-2:0], samp};
            if (bitcnt == LAST) begin
              bitcnt <= '0;
              done   <= 1'b1;
            end else begin
              bitcnt <= bitcnt + CNT_W'(1);
            end
          end
          if (load && !busy) shreg <= load_data;
        end
        default: begin
          bitcnt  <= '0;
          lead    <= 1'b0;
          mbusy   <= 1'b0;
          sck_lvl <= cpol;
        end
      endcase
    end
  end

  // R7: an idle master parks SCK at the polarity level
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_MASTER && !mbusy) |=> (sck_lvl == $past(cpol)));

  // R12: a deselected gated slave holds its bit position at zero
  p_deselect_r12: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_SLAVE && ss_ctl && ss_n_s) |=> (bitcnt == '0 && !lead));

endmodule

// File: rtl/spi_port.sv
module spi_port import spi_port_pkg::*; #(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              timer_tick,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              ss_n
);

  logic                wcol_q, rov_q, en_q, cpol_q, full_q;
  logic [3:0]          mode_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [DATA_W-1:0]   rxbuf_q;
  mode_cfg_t           cfg;

  logic [1:0] sck_sync, ss_sync, sdi_sync;
  logic       ctrl_wr, buf_wr, buf_rd, load, collide, ovf_set, run;
  logic       busy, done, half_pulse, sck_lvl, sdo_bit;
  logic [DATA_W-1:0] rx_data;

  assign cfg = decode_mode(en_q, mode_q);

  assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);
  assign buf_wr  = bus_wr && (bus_sel == SEL_BUF);
  assign buf_rd  = bus_rd && (bus_sel == SEL_BUF);
  assign load    = buf_wr && (cfg.role != ROLE_OFF);
  assign collide = load && busy;
  assign ovf_set = done && (cfg.role == ROLE_SLAVE) && full_q;
  assign run     = (cfg.role == ROLE_MASTER) && busy;

  // two-stage synchronisers for the externally timed inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync <= '0;
      ss_sync  <= '1;
      sdi_sync <= '0;
    end else begin
      sck_sync <= {sck_sync[0], sck_in};
      ss_sync  <= {ss_sync[0], ss_n};
      sdi_sync <= {sdi_sync[0], sdi};
    end
  end

  spi_clkgen #(.RELOAD_W(RELOAD_W)) u_clkgen (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .src        (cfg.src),
    .reload     (reload_q),
    .timer_tick (timer_tick),
    .half_pulse (half_pulse)
  );

  spi_shifter #(.W(DATA_W)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .role       (cfg.role),
    .ss_ctl     (cfg.ss_ctl),
    .cpol       (cpol_q),
    .half_pulse (half_pulse),
    .load       (load),
    .load_data  (bus_wdata),
    .sdi_raw    (sdi),
    .sdi_s      (sdi_sync[1]),
    .sck_s      (sck_sync[1]),
    .ss_n_s     (ss_sync[1]),
    .busy       (busy),
    .done       (done),
    .rx_data    (rx_data),
    .sck_lvl    (sck_lvl),
    .sdo_bit    (sdo_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wcol_q    <= 1'b0;
      rov_q     <= 1'b0;
      en_q      <= 1'b0;
      cpol_q    <= 1'b0;
      mode_q    <= '0;
      reload_q  <= '0;
      rxbuf_q   <= '0;
      full_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= bus_wdata[5];
        cpol_q <= bus_wdata[4];
        mode_q <= bus_wdata[3:0];
      end
      if (bus_wr && bus_sel == SEL_RELOAD) reload_q <= bus_wdata[RELOAD_W-1:0];
      // sticky flags: hardware sets, a written zero clears, a written one keeps
      wcol_q <= collide || (wcol_q && !(ctrl_wr && !bus_wdata[7]));
      rov_q  <= ovf_set || (rov_q && !(ctrl_wr && !bus_wdata[6]));

      if (done && (cfg.role == ROLE_MASTER || (cfg.role == ROLE_SLAVE && !full_q))) begin
        rxbuf_q <= rx_data;
        full_q  <= 1'b1;
      end else if (buf_rd) begin
        full_q <= 1'b0;
      end

      if (bus_rd) begin
        case (bus_sel)
          SEL_CTRL:   bus_rdata <= DATA_W'({wcol_q, rov_q, en_q, cpol_q, mode_q});
          SEL_BUF:    bus_rdata <= rxbuf_q;
          SEL_RELOAD: bus_rdata <= DATA_W'(reload_q);
          default:    bus_rdata <= DATA_W'(full_q);
        endcase
      end
    end
  end

  assign sck_out = sck_lvl;
  assign sck_oe  = (cfg.role == ROLE_MASTER);
  assign sdo     = sdo_bit;
  assign sdo_oe  = (cfg.role == ROLE_MASTER) ||
                   ((cfg.role == ROLE_SLAVE) && !(cfg.ss_ctl && ss_sync[1]));

  // R11: a master never raises the overflow flag
  p_master_no_ovf_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg.role == ROLE_MASTER && !rov_q) |=> !rov_q);

  // R8: collision flag survives anything but a zero written to bit 7
  p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (wcol_q && !(ctrl_wr && !bus_wdata[7])) |=> wcol_q);

  // R10: an overflowing slave byte leaves the buffer untouched
  p_ovf_keeps_buf_r10: assert property (@(posedge clk) disable iff (rst)
    (done && cfg.role == ROLE_SLAVE && full_q) |=> $stable(rxbuf_q));

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  import spi_port_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_sel;
  logic [7:0] bus_wdata, bus_rdata;
  logic       timer_tick;
  logic       sck_in, sck_out, sck_oe, sdi, sdo, sdo_oe, ss_n;
  logic       tick_en;
  logic       rd_d;
  int         total = 0;
  int         bad = 0;
  int         tcnt = 0;
  logic [7:0] q_exp[$];
  logic [7:0] q_mask[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_tick(timer_tick),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  always @(negedge clk) begin
    if (tick_en) begin
      tcnt = tcnt + 1;
      timer_tick = (tcnt % 5 == 0);
    end else begin
      tcnt = 0;
      timer_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per read strobe
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d && q_exp.size() > 0) begin
      logic [7:0] e, m;
      string t;
      e = q_exp.pop_front();
      m = q_mask.pop_front();
      t = q_tag.pop_front();
      chk(t, int'(bus_rdata & m), int'(e & m), "register read");
    end
  end

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] sel, input logic [7:0] exp,
                          input logic [7:0] mask, input string tag);
    @(negedge clk);
    q_exp.push_back(exp); q_mask.push_back(mask); q_tag.push_back(tag);
    bus_sel = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  // bench acts as an SPI slave for the DUT master
  task automatic run_master(input logic [7:0] tx, input logic [7:0] miso, input int half,
                            input logic pol, input string tag, input bit collide);
    int toggles = 0, gap = 0, cyc = 0, bitsout = 1, extra = 0;
    bit gap_ok = 1, wrote = 0;
    logic prev;
    logic [7:0] got = '0;
    sdi = miso[7];
    bus_write(SEL_BUF, tx);
    prev = sck_out;
    while (toggles < 16 && cyc < 20000) begin
      @(negedge clk);
      cyc++; gap++;
      if (bus_wr) bus_wr = 1'b0;
      if (sck_out !== prev) begin
        toggles++;
        if (toggles > 1 && gap != half) gap_ok = 0;
        gap = 0;
        if (sck_out != pol) got = {got[6:0], sdo};
        else if (bitsout < 8) begin sdi = miso[7 - bitsout]; bitsout++; end
        prev = sck_out;
        if (collide && toggles == 5 && !wrote) begin
          bus_sel = SEL_BUF; bus_wdata = 8'hFF; bus_wr = 1'b1; wrote = 1;
        end
      end
    end
    chk(tag, gap_ok, 1, "SCK half period");
    chk("R6", toggles, 16, "SCK toggles per transfer");
    chk("R6", got, tx, "MSB-first byte on sdo");
    repeat (4 * half) begin
      @(negedge clk);
      if (sck_out !== prev) extra++;
    end
    chk("R6", extra, 0, "no SCK activity after eight cycles");
    chk("R7", sck_out, pol, "SCK idle level after transfer");
  endtask

  // bench acts as an SPI master driving the DUT slave
  task automatic run_slave(input logic [7:0] mosi, input logic pol, input bit drive_ss,
                           input int nbits, output logic [7:0] got);
    got = '0;
    if (drive_ss) ss_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck_in = pol;
      sdi = mosi[7 - i];
      repeat (6) @(negedge clk);
      got = {got[6:0], sdo};
      sck_in = ~pol;
      repeat (6) @(negedge clk);
      sck_in = pol;
    end
    repeat (6) @(negedge clk);
    if (drive_ss) ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired during R6/R9 transfer activity");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int moves;
    logic p;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
    sdi = 0; sck_in = 0; ss_n = 1; tick_en = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", sck_oe, 0, "sck_oe after reset");
    chk("R1", sdo_oe, 0, "sdo_oe after reset");
    bus_read(SEL_CTRL, 8'h00, 8'hFF, "R1");
    bus_read(SEL_STAT, 8'h00, 8'hFF, "R1");

    // R13 disabled and reserved modes
    bus_write(SEL_BUF, 8'h77);
    moves = 0; p = sck_out;
    repeat (40) begin @(negedge clk); if (sck_out !== p || sck_oe) moves++; end
    chk("R13", moves, 0, "no SCK while disabled");
    bus_write(SEL_CTRL, 8'h29);
    repeat (2) @(negedge clk);
    chk("R13", sck_oe | sdo_oe, 0, "enables low in reserved mode");
    bus_write(SEL_BUF, 8'h77);
    repeat (40) @(negedge clk);
    bus_read(SEL_STAT, 8'h00, 8'hFF, "R13");

    // R3 fixed dividers, R2 register map
    bus_write(SEL_CTRL, 8'h20);
    bus_read(SEL_CTRL, 8'h20, 8'hFF, "R2");
    chk("R6", sck_oe, 1, "master drives SCK");
    run_master(8'hA5, 8'h3C, 2, 1'b0, "R3", 0);
    bus_read(SEL_STAT, 8'h01, 8'hFF, "R6");
    bus_read(SEL_BUF, 8'h3C, 8'hFF, "R6");
    bus_read(SEL_STAT, 8'h00, 8'hFF, "R14");
    bus_write(SEL_CTRL, 8'h21);
    run_master(8'h81, 8'h7E, 8, 1'b0, "R3", 0);
    bus_read(SEL_BUF, 8'h7E, 8'hFF, "R3");
    bus_write(SEL_CTRL, 8'h22);
    run_master(8'h5B, 8'hC6, 32, 1'b0, "R3", 0);

    // R11 master never overflows, buffer overwritten
    bus_write(SEL_CTRL, 8'h20);
    run_master(8'h12, 8'h34, 2, 1'b0, "R11", 0);
    bus_read(SEL_CTRL, 8'h00, 8'h40, "R11");
    bus_read(SEL_BUF, 8'h34, 8'hFF, "R11");

    // R5 reload divider with R7 high idle
    bus_write(SEL_RELOAD, 8'h03);
    bus_read(SEL_RELOAD, 8'h03, 8'hFF, "R2");
    bus_write(SEL_CTRL, 8'h3A);
    repeat (2) @(negedge clk);
    chk("R7", sck_out, 1, "idle high with polarity 1");
    run_master(8'hE7, 8'h18, 8, 1'b1, "R5", 0);
    bus_read(SEL_BUF, 8'h18, 8'hFF, "R5");

    // R4 timer-tick source
    tick_en = 1'b1;
    bus_write(SEL_CTRL, 8'h23);
    run_master(8'h69, 8'h96, 5, 1'b0, "R4", 0);
    tick_en = 1'b0;
    bus_read(SEL_BUF, 8'h96, 8'hFF, "R4");

    // R8 write collision
    bus_write(SEL_CTRL, 8'h21);
    run_master(8'hC3, 8'h55, 8, 1'b0, "R8", 1);
    bus_read(SEL_CTRL, 8'hA1, 8'hFF, "R8");
    bus_write(SEL_CTRL, 8'hA1);
    bus_read(SEL_CTRL, 8'hA1, 8'hFF, "R8");
    bus_write(SEL_CTRL, 8'h21);
    bus_read(SEL_CTRL, 8'h21, 8'hFF, "R8");
    bus_read(SEL_BUF, 8'h55, 8'hFF, "R8");

    // R9 slave transfer with select control
    sck_in = 1'b0; ss_n = 1'b1;
    bus_write(SEL_CTRL, 8'h24);
    repeat (4) @(negedge clk);
    chk("R12", sdo_oe, 0, "sdo_oe low while deselected");
    chk("R12", sck_oe, 0, "slave does not drive SCK");
    bus_write(SEL_BUF, 8'h96);
    run_slave(8'h5A, 1'b0, 1, 8, got);
    chk("R9", got, 8'h96, "slave byte on sdo");
    bus_read(SEL_STAT, 8'h01, 8'hFF, "R9");
    bus_read(SEL_BUF, 8'h5A, 8'hFF, "R9");

    // R10 slave overflow
    run_slave(8'h11, 1'b0, 1, 8, got);
    run_slave(8'h22, 1'b0, 1, 8, got);
    bus_read(SEL_CTRL, 8'h64, 8'hFF, "R10");
    bus_read(SEL_BUF, 8'h11, 8'hFF, "R10");
    bus_write(SEL_CTRL, 8'h24);
    bus_read(SEL_CTRL, 8'h24, 8'hFF, "R10");

    // R12 deselected edges ignored, aborted transfer restarts count
    run_slave(8'hFF, 1'b0, 0, 8, got);
    bus_read(SEL_STAT, 8'h00, 8'hFF, "R12");
    run_slave(8'hF0, 1'b0, 1, 3, got);
    run_slave(8'h3C, 1'b0, 1, 8, got);
    bus_read(SEL_BUF, 8'h3C, 8'hFF, "R12");

    // R12 mode 0101 ignores the select line
    bus_write(SEL_CTRL, 8'h25);
    repeat (4) @(negedge clk);
    chk("R12", sdo_oe, 1, "sdo_oe high with select ignored");
    bus_write(SEL_BUF, 8'hA3);
    run_slave(8'hC5, 1'b0, 0, 8, got);
    chk("R12", got, 8'hA3, "slave sends with select high");
    bus_read(SEL_BUF, 8'hC5, 8'hFF, "R12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule